// File: doc/BRIEF.md
# Gshare Branch Predictor with Target Buffer

This block sits beside the fetch stage of a 32-bit in-order pipeline and guesses where the next fetch goes. In the fetch cycle it takes the fetch PC and the 7-bit opcode of the fetched word. It returns the predicted next PC and a predicted-taken bit. The guess needs a target-buffer hit. Unconditional jumps (jal, jalr) found in the buffer are always taken. A conditional branch found in the buffer follows the top bit of a 2-bit saturating counter. That counter is selected by hashing the PC with a global history of recent branch outcomes (gshare).

In the execute cycle the pipeline returns the resolved instruction: its PC and PC+4, a one-hot kind (conditional branch, jal or jalr), the actual outcome, the PC-relative target and the ALU result. The block trains its tables with this information. It also computes the PC that fetch must restart from when the pipeline flags a misprediction. Deciding that a misprediction happened and flushing the stages stay with the pipeline.

Top module: `gsh_predictor`

## Requirements
- R1: After reset every target-buffer entry is invalid, the history is all zeros and every counter holds 2'b01 (weakly not taken).
- R2: The target buffer is direct mapped. It is indexed by PC bits [11:2] and tagged with all other PC bits. On a miss, or whenever the prediction is not taken, the next PC is the fetch PC + 4.
- R3: A fetch whose opcode is jal (7'b1101111) or jalr (7'b1100111) and which hits the buffer is predicted taken, whatever the counters hold. The next PC is then the stored target.
- R4: A fetch whose opcode is a conditional branch (7'b1100011) and which hits the buffer is predicted taken exactly when bit 1 of the counter at index PC[11:2] XOR history is set. A fetch with any other opcode is never predicted taken.
- R5: The buffer entry for the execute PC is written (set valid, tag, target) for jal, for jalr and for a taken conditional branch. A not-taken branch writes nothing. The stored target is the ALU result with bit 0 cleared for jalr, and the PC-relative target otherwise.
- R6: On each resolved conditional branch, the counter at execute PC[11:2] XOR history (the history value before this update) increments toward 3 if taken and decrements toward 0 if not. It saturates at both ends. Jumps leave counters alone.
- R7: On each resolved conditional branch the 10-bit history shifts left and takes the actual outcome in bit 0. Jumps and idle cycles leave it unchanged.
- R8: The recovery PC is the ALU result with bit 0 cleared for jalr. It is the PC-relative target for jal or a taken branch. In every other case it is the execute PC+4.
- R9: An update becomes visible to fetch from the next cycle on. A fetch in the same cycle as an update to the entry it reads sees the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pc_f | input | 32 | Fetch PC |
| opcode_f | input | 7 | Opcode field of the fetched instruction |
| pred_taken_f | output | 1 | Fetch is predicted taken |
| pred_next_pc_f | output | 32 | Predicted next fetch PC |
| pc_e | input | 32 | PC of the instruction in execute |
| pc_plus4_e | input | 32 | Execute PC + 4 |
| branch_e | input | 1 | Execute holds a conditional branch |
| jal_e | input | 1 | Execute holds a jal |
| jalr_e | input | 1 | Execute holds a jalr |
| taken_e | input | 1 | Resolved outcome of the conditional branch |
| target_e | input | 32 | PC + immediate computed in execute |
| alu_res_e | input | 32 | ALU result (jalr target before clearing bit 0) |
| recover_pc_e | output | 32 | Restart PC for a misprediction |

## Verification
A fetch lookup and an execute update can hit the same buffer entry or the same counter in one cycle. The bench provokes this on purpose: it fetches the very PC that execute is resolving, and in the random phase it draws both PCs from a small pool that also contains an alias of the same index with another tag. A behavioural model applies each update only after the edge, so every cycle it judges that fetch saw the pre-update contents and that the next cycle sees the new ones.

// File: rtl/bp_pkg.sv
// Shared constants and helpers for the gshare predictor.
// Assumes RV32 opcode encodings in instruction bits [6:0].
package bp_pkg;

    localparam logic [6:0] OPC_BRANCH = 7'b1100011;
    localparam logic [6:0] OPC_JAL    = 7'b1101111;
    localparam logic [6:0] OPC_JALR   = 7'b1100111;

    localparam logic [1:0] CTR_WEAK_NT = 2'b01;

    typedef enum logic [1:0] {
        FK_OTHER  = 2'd0,
        FK_BRANCH = 2'd1,
        FK_JUMP   = 2'd2
    } fetch_kind_e;

    // Classify a fetched opcode for the prediction rule.
    function automatic fetch_kind_e classify(input logic [6:0] opc);
        if (opc == OPC_JAL || opc == OPC_JALR) return FK_JUMP;
        if (opc == OPC_BRANCH)                 return FK_BRANCH;
        return FK_OTHER;
    endfunction

    // One step of a 2-bit saturating counter.
    function automatic logic [1:0] ctr_step(input logic [1:0] c, input logic up);
        if (up)  return (c == 2'b11) ? c : c + 2'b01;
        return (c == 2'b00) ? c : c - 2'b01;
    endfunction

endpackage

// File: rtl/bp_history.sv
// Global history register plus pattern table of 2-bit counters (gshare).
// Read is combinational on registered state; the update lands at the edge.
// Assumes the caller passes the PC index bits already sliced.
module bp_history #(
    parameter int HIST_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HIST_W-1:0] rd_pc_idx,
    output logic              rd_taken,
    input  logic              upd_en,
    input  logic [HIST_W-1:0] upd_pc_idx,
    input  logic              upd_taken
);
    import bp_pkg::*;

    localparam int ENTRIES = 1 << HIST_W;

    logic [HIST_W-1:0] ghr_q;
    logic [1:0]        ctr_q [ENTRIES];
    logic [HIST_W-1:0] rd_idx;
    logic [HIST_W-1:0] upd_idx;

    // Hash both ports' PC bits with the current history.
    always_comb begin
        rd_idx  = rd_pc_idx ^ ghr_q;
        upd_idx = upd_pc_idx ^ ghr_q;
    end

    // Prediction is the counter's upper bit.
    assign rd_taken = ctr_q[rd_idx][1];

    // Shift the resolved outcome into the history.
    always_ff @(posedge clk) begin
        if (!rst_n)      ghr_q <= '0;
        else if (upd_en) ghr_q <= {ghr_q[HIST_W-2:0], upd_taken};
    end

    // Train the selected counter, or reset all to weakly not taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) ctr_q[i] <= CTR_WEAK_NT;
        end else if (upd_en) begin
            ctr_q[upd_idx] <= ctr_step(ctr_q[upd_idx], upd_taken);
        end
    end

endmodule

// File: rtl/bp_target_buf.sv
// Direct-mapped target buffer with valid bit and tag per entry.
// The tag holds every PC bit outside the index field, so a misaligned
// PC can never alias an aligned one. Only the valid bits are reset.
module bp_target_buf #(
    parameter int XLEN  = 32,
    parameter int DEPTH = 1024
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [XLEN-1:0] rd_pc,
    output logic            rd_hit,
    output logic [XLEN-1:0] rd_target,
    input  logic            wr_en,
    input  logic [XLEN-1:0] wr_pc,
    input  logic [XLEN-1:0] wr_target
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam int TAG_W = XLEN - IDX_W;
    localparam int IDX_LO = 2;

    logic [DEPTH-1:0] valid_q;
    logic [TAG_W-1:0] tag_q [DEPTH];
    logic [XLEN-1:0]  tgt_q [DEPTH];

    logic [IDX_W-1:0] rd_idx, wr_idx;
    logic [TAG_W-1:0] rd_tag, wr_tag;

    // Split each PC into index and the remaining tag bits.
    always_comb begin
        rd_idx = rd_pc[IDX_LO +: IDX_W];
        wr_idx = wr_pc[IDX_LO +: IDX_W];
        rd_tag = {rd_pc[XLEN-1:IDX_LO+IDX_W], rd_pc[IDX_LO-1:0]};
        wr_tag = {wr_pc[XLEN-1:IDX_LO+IDX_W], wr_pc[IDX_LO-1:0]};
    end

    // Hit needs a valid entry with a matching tag.
    assign rd_hit    = valid_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
    assign rd_target = tgt_q[rd_idx];

    // Valid bits: cleared by reset, set on each write.
    always_ff @(posedge clk) begin
        if (!rst_n)     valid_q <= '0;
        else if (wr_en) valid_q[wr_idx] <= 1'b1;
    end

    // Tag and target storage, no reset needed behind the valid bit.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx] <= wr_tag;
            tgt_q[wr_idx] <= wr_target;
        end
    end

endmodule

// File: rtl/bp_resolve.sv
// Execute-side decisions: buffer write enable and data, history update
// enable, and the misprediction restart PC.
// Assumes branch_e, jal_e and jalr_e are never set together.
module bp_resolve #(
    parameter int XLEN = 32
) (
    input  logic            branch_e,
    input  logic            jal_e,
    input  logic            jalr_e,
    input  logic            taken_e,
    input  logic [XLEN-1:0] pc_plus4_e,
    input  logic [XLEN-1:0] target_e,
    input  logic [XLEN-1:0] alu_res_e,
    output logic            btb_wr,
    output logic [XLEN-1:0] btb_wr_target,
    output logic            hist_upd,
    output logic [XLEN-1:0] recover_pc
);
    logic            went_taken;
    logic [XLEN-1:0] jalr_tgt;

    // Resolved direction and the jalr target with bit 0 forced low.
    always_comb begin
        went_taken = jal_e || jalr_e || (branch_e && taken_e);
        jalr_tgt   = alu_res_e & ~XLEN'(1);
    end

    // Table training controls.
    always_comb begin
        btb_wr        = went_taken;
        btb_wr_target = jalr_e ? jalr_tgt : target_e;
        hist_upd      = branch_e;
    end

    // Restart PC: the real target when taken, else the fall-through.
    always_comb begin
        if (jalr_e)          recover_pc = jalr_tgt;
        else if (went_taken) recover_pc = target_e;
        else                 recover_pc = pc_plus4_e;
    end

endmodule

// File: rtl/gsh_predictor.sv
// Fetch-stage dynamic predictor: gshare direction tables plus a
// direct-mapped target buffer, trained from execute. Prediction is a
// pure function of registered state and fetch inputs (same-cycle
// updates are not bypassed).
module gsh_predictor #(
    parameter int XLEN      = 32,
    parameter int HIST_W    = 10,
    parameter int BTB_DEPTH = 1024
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [XLEN-1:0] pc_f,
    input  logic [6:0]      opcode_f,
    output logic            pred_taken_f,
    output logic [XLEN-1:0] pred_next_pc_f,
    input  logic [XLEN-1:0] pc_e,
    input  logic [XLEN-1:0] pc_plus4_e,
    input  logic            branch_e,
    input  logic            jal_e,
    input  logic            jalr_e,
    input  logic            taken_e,
    input  logic [XLEN-1:0] target_e,
    input  logic [XLEN-1:0] alu_res_e,
    output logic [XLEN-1:0] recover_pc_e
);
    import bp_pkg::*;

    localparam int PC_LO = 2;

    logic            hit_f;
    logic [XLEN-1:0] btb_tgt_f;
    logic            dir_taken_f;
    fetch_kind_e     kind_f;

    logic            btb_wr;
    logic [XLEN-1:0] btb_wr_target;
    logic            hist_upd;

    bp_target_buf #(.XLEN(XLEN), .DEPTH(BTB_DEPTH)) u_btb (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_pc     (pc_f),
        .rd_hit    (hit_f),
        .rd_target (btb_tgt_f),
        .wr_en     (btb_wr),
        .wr_pc     (pc_e),
        .wr_target (btb_wr_target)
    );

    bp_history #(.HIST_W(HIST_W)) u_hist (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_pc_idx  (pc_f[PC_LO +: HIST_W]),
        .rd_taken   (dir_taken_f),
        .upd_en     (hist_upd),
        .upd_pc_idx (pc_e[PC_LO +: HIST_W]),
        .upd_taken  (taken_e)
    );

    bp_resolve #(.XLEN(XLEN)) u_res (
        .branch_e      (branch_e),
        .jal_e         (jal_e),
        .jalr_e        (jalr_e),
        .taken_e       (taken_e),
        .pc_plus4_e    (pc_plus4_e),
        .target_e      (target_e),
        .alu_res_e     (alu_res_e),
        .btb_wr        (btb_wr),
        .btb_wr_target (btb_wr_target),
        .hist_upd      (hist_upd),
        .recover_pc    (recover_pc_e)
    );

    // Combine opcode class, buffer hit and counter into the guess.
    always_comb begin
        kind_f = classify(opcode_f);
        unique case (kind_f)
            FK_JUMP:   pred_taken_f = hit_f;
            FK_BRANCH: pred_taken_f = hit_f && dir_taken_f;
            default:   pred_taken_f = 1'b0;
        endcase
        pred_next_pc_f = pred_taken_f ? btb_tgt_f : pc_f + XLEN'(4);
    end

endmodule

// File: rtl/gsh_predictor_chk.sv
// Port-level properties of the predictor, bound to every instance.
module gsh_predictor_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic [XLEN-1:0] pc_f,
    input logic [6:0]      opcode_f,
    input logic            pred_taken_f,
    input logic [XLEN-1:0] pred_next_pc_f,
    input logic [XLEN-1:0] pc_e,
    input logic            branch_e,
    input logic            jal_e,
    input logic            jalr_e,
    input logic [XLEN-1:0] target_e,
    input logic [XLEN-1:0] recover_pc_e
);
    import bp_pkg::*;

    // R2
    fallthrough_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pred_taken_f |-> pred_next_pc_f == pc_f + XLEN'(4));

    // R4
    non_ctl_opcode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode_f != OPC_BRANCH && opcode_f != OPC_JAL && opcode_f != OPC_JALR)
        |-> !pred_taken_f);

    // R8
    jalr_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
        jalr_e |-> !recover_pc_e[0]);

    // R5
    jal_learned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        jal_e |=> ((pc_f == $past(pc_e) && opcode_f == OPC_JAL)
                   -> (pred_taken_f && pred_next_pc_f == $past(target_e))));

    // R9
    quiet_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(pc_f) && $stable(opcode_f) && !$past(branch_e || jal_e || jalr_e))
        |-> ($stable(pred_taken_f) && $stable(pred_next_pc_f)));

endmodule

bind gsh_predictor gsh_predictor_chk #(.XLEN(XLEN)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .pc_f           (pc_f),
    .opcode_f       (opcode_f),
    .pred_taken_f   (pred_taken_f),
    .pred_next_pc_f (pred_next_pc_f),
    .pc_e           (pc_e),
    .branch_e       (branch_e),
    .jal_e          (jal_e),
    .jalr_e         (jalr_e),
    .target_e       (target_e),
    .recover_pc_e   (recover_pc_e)
);

// File: tb/gsh_predictor_test.sv
`timescale 1ns/1ps
// Bench: behavioural reference model compared on every clock.
module gsh_predictor_test;

    localparam logic [6:0] BR = 7'b1100011, JL = 7'b1101111, JR = 7'b1100111, AL = 7'b0110011;

    logic        clk = 0, rst_n = 0;
    logic [31:0] pc_f = 0, pc_e = 0, pc_plus4_e = 4, target_e = 0, alu_res_e = 0;
    logic [6:0]  opcode_f = AL;
    logic        branch_e = 0, jal_e = 0, jalr_e = 0, taken_e = 0;
    wire         pred_taken_f;
    wire  [31:0] pred_next_pc_f, recover_pc_e;

    int vectors = 0, errors = 0;
    bit done = 0;

    // Reference state
    int          m_ctr [1024];
    int          m_ghr;
    bit          m_vld [1024];
    logic [31:0] m_tag [1024];
    logic [31:0] m_tgt [1024];

    always #4 clk = ~clk;

    gsh_predictor uut (
        .clk(clk), .rst_n(rst_n), .pc_f(pc_f), .opcode_f(opcode_f),
        .pred_taken_f(pred_taken_f), .pred_next_pc_f(pred_next_pc_f),
        .pc_e(pc_e), .pc_plus4_e(pc_plus4_e), .branch_e(branch_e), .jal_e(jal_e),
        .jalr_e(jalr_e), .taken_e(taken_e), .target_e(target_e),
        .alu_res_e(alu_res_e), .recover_pc_e(recover_pc_e)
    );

    task automatic compare(string tag, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // R1: model reset contents
    task automatic model_reset();
        for (int i = 0; i < 1024; i++) begin
            m_ctr[i] = 1; m_vld[i] = 0; m_tag[i] = 0; m_tgt[i] = 0;
        end
        m_ghr = 0;
    endtask

    // One cycle: kind 0 idle, 1 branch, 2 jal, 3 jalr.
    task automatic step(string tag, logic [31:0] fpc, logic [6:0] op, int kind,
                        bit tk, logic [31:0] epc, logic [31:0] tgt, logic [31:0] alu);
        int idx, pidx;
        bit hit, exp_t;
        logic [31:0] exp_pc, exp_rec, jt;
        string ftag;
        @(negedge clk);
        pc_f = fpc; opcode_f = op; pc_e = epc; pc_plus4_e = epc + 4;
        branch_e = (kind == 1); jal_e = (kind == 2); jalr_e = (kind == 3);
        taken_e = tk; target_e = tgt; alu_res_e = alu;
        #1;
        idx = int'(fpc[11:2]);
        hit = m_vld[idx] && (m_tag[idx] == (fpc & 32'hFFFF_F003));
        if (op == JL || op == JR) exp_t = hit;
        else if (op == BR) exp_t = hit && (m_ctr[(idx ^ m_ghr) % 1024] >= 2);
        else exp_t = 0;
        exp_pc = exp_t ? m_tgt[idx] : fpc + 4;
        ftag = (tag != "") ? tag : (op == JL || op == JR) ? "R3" : (op == BR) ? "R4" : "R2";
        compare({ftag, " pred_taken"}, {31'b0, pred_taken_f}, {31'b0, exp_t});
        compare({ftag, " next_pc"}, pred_next_pc_f, exp_pc);
        jt = alu & 32'hFFFF_FFFE;
        if (kind == 3) exp_rec = jt;
        else if (kind == 2 || (kind == 1 && tk)) exp_rec = tgt;
        else exp_rec = epc + 4;
        compare("R8 recover_pc", recover_pc_e, exp_rec);
        @(posedge clk);
        // R5, R6, R7: model update after the edge
        if (kind == 1) begin
            pidx = (int'(epc[11:2]) ^ m_ghr) % 1024;
            if (tk && m_ctr[pidx] < 3) m_ctr[pidx]++;
            if (!tk && m_ctr[pidx] > 0) m_ctr[pidx]--;
            m_ghr = ((m_ghr << 1) | int'(tk)) % 1024;
        end
        if (kind == 2 || kind == 3 || (kind == 1 && tk)) begin
            idx = int'(epc[11:2]);
            m_vld[idx] = 1;
            m_tag[idx] = epc & 32'hFFFF_F003;
            m_tgt[idx] = (kind == 3) ? jt : tgt;
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] pool [6];
        model_reset();
        pool[0] = 32'h100; pool[1] = 32'h104; pool[2] = 32'h1100;
        pool[3] = 32'h200; pool[4] = 32'h7F0; pool[5] = 32'h400;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R1: empty tables after reset, every opcode falls through
        step("R1", 32'h100, BR, 0, 0, 0, 0, 0);
        step("R1", 32'h300, JL, 0, 0, 0, 0, 0);
        // R6/R7: first taken branch writes buffer, counter 1->2 at index ^0
        step("R6", 32'h100, BR, 1, 1, 32'h100, 32'h80, 0);
        // history now 1: index differs, counter there still weak NT
        step("R7", 32'h100, BR, 0, 0, 0, 0, 0);
        for (int i = 0; i < 14; i++)
            step("R6", 32'h100, BR, 1, 1, 32'h100, 32'h80, 0);
        step("R4", 32'h100, BR, 0, 0, 0, 0, 0);
        step("R6", 32'h100, BR, 1, 0, 32'h100, 32'h80, 0);
        step("R7", 32'h100, BR, 0, 0, 0, 0, 0);
        // R5: not-taken branch at a new PC writes nothing
        step("R5", 32'h200, BR, 1, 0, 32'h200, 32'h40, 0);
        step("R5", 32'h200, BR, 0, 0, 0, 0, 0);
        // R9: fetch same PC as jal update sees old entry, then new
        step("R9", 32'h300, JL, 2, 1, 32'h300, 32'h900, 0);
        step("R5", 32'h300, JL, 0, 0, 0, 0, 0);
        // R5/R8: jalr with odd ALU result, bit 0 cleared
        step("R8", 32'h400, JR, 3, 0, 32'h400, 32'h0, 32'h1235);
        step("R3", 32'h400, JR, 0, 0, 0, 0, 0);
        // R2: alias with same index, different tag, misses
        step("R2", 32'h1100, BR, 0, 0, 0, 0, 0);
        step("R2", 32'h300, AL, 0, 0, 0, 0, 0);
        // Mixed random traffic over a small colliding PC pool
        for (int n = 0; n < 4000; n++) begin
            int k, o;
            logic [6:0] op;
            logic [31:0] fp, ep;
            k = $urandom_range(0, 3);
            o = $urandom_range(0, 3);
            op = (o == 0) ? BR : (o == 1) ? JL : (o == 2) ? JR : AL;
            ep = pool[$urandom_range(0, 5)];
            fp = ($urandom_range(0, 3) == 0) ? ep : pool[$urandom_range(0, 5)];
            step("", fp, op, k, 1'($urandom_range(0, 1)), ep,
                 {$urandom_range(0, 65535), 2'b00} , $urandom());
        end
        // R1: reset again clears learned state
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1;
        model_reset();
        step("R1", 32'h300, JL, 0, 0, 0, 0, 0);
        step("R1", 32'h100, BR, 0, 0, 0, 0, 0);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule